// File: doc/BRIEF.md
# Keyed-Reload Watchdog Timer

This block is a memory-mapped watchdog timer. Software selects a timeout from a fixed, irregular set of intervals. It then enables the counter and must refresh it before the interval runs out. The only way to refresh it is to write one exact key word to the restart register. A stray write of any other value cannot keep the system alive.

The counter advances on a half-second tick-enable input. It runs only while the enable bit is set. When the count runs out and the expiry action field selects reset, the block drives a fixed-length pulse on its system-reset output. It also sets a sticky expired flag, which software can read back and which the next keyed restart clears. The register access is single-cycle: writes take effect at the clock edge, and reads are combinational.

Top module: `wdog_keyed`

## Requirements
- R1: The restart register is at offset 0x10, the action register at 0x14 and the mode register at 0x18. Reading the action register returns its bits [1:0] and zero above them. Reading the mode register returns the enable bit at bit 0 and the timeout code at bits [7:4], with all other bits zero. Reading any other offset returns 0.
- R2: A write of exactly 0x0000_14AF (bit 0 set, key 0xA57 in bits [12:1]) to the restart register reloads the counter and clears the expired flag. Any other value written there changes nothing.
- R3: Bit 0 of the mode register enables counting. Writing 0 to the mode register stops the watchdog. While the watchdog is disabled, ticks never cause an expiry.
- R4: The timeout code in mode bits [7:4] selects the interval in half-second ticks: code 0 gives 1 tick, codes 1 to 6 give 2 to 12 ticks, and codes 7, 8, 9, 0xA and 0xB give 16, 20, 24, 28 and 32 ticks.
- R5: Codes 0xC to 0xF give the same interval as code 0xB, which is 32 ticks.
- R6: After reset the watchdog is disabled, the timeout code is 0, the action field is 0, the expired flag is clear and the reset output is low.
- R7: When enabled, the Nth tick after a reload is the expiry, where N is the selected interval. If the action field equals 1, the reset output is high for exactly 4 clock cycles starting at the edge after the expiry tick, and restart-register bit 31 reads 1. With any other action value, the reset output stays low and the flag stays clear.
- R8: Writing the mode register with the enable bit already set and the same timeout code does not reload the counter and keeps the code.
- R9: A mode write that changes the timeout code, or that sets the enable bit from 0 to 1, reloads the counter with the new interval.
- R10: Reading the restart register returns the expired flag at bit 31 and zero in all other bits, including the key bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Half-second count enable |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | ADDR_W | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| sysRstOut | output | 1 | System reset pulse |

## Verification
The checker watches several properties on every cycle. A keyed restart always leaves the flag clear, and a wrong key never clears it. The reset output never rises while the watchdog is disabled or the action is not 1. Every reset pulse lasts at least four cycles and coincides with the flag being set. The key bits always read back as zero. Only the directed scenarios can show the things that depend on counting over many ticks. These are the exact tick count for each timeout code, and the fact that a same-value rewrite of the mode register does not reload the counter while a changed code does. They also show that a rejected key leaves the pending expiry in place.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W = 6;
  localparam int DATA_W = 32;
  localparam logic [7:0] OFF_CTRL = 8'h10;
  localparam logic [7:0] OFF_CFG  = 8'h14;
  localparam logic [7:0] OFF_MODE = 8'h18;
  localparam logic [DATA_W-1:0] RESTART_WORD = 32'h0000_14AF;

  typedef struct packed {
    logic       reload;
    logic       clearExp;
    logic [3:0] loadCode;
  } wdStrobe_t;

  // Interval in half-second ticks for a timeout code (R4, R5)
  function automatic logic [CNT_W-1:0] ticksFor(input logic [3:0] code);
    logic [CNT_W-1:0] t;
    if (code == 4'd0)       t = CNT_W'(1);
    else if (code <= 4'd6)  t = CNT_W'({code, 1'b0});
    else if (code <= 4'hB)  t = CNT_W'(16 + 4 * (int'(code) - 7));
    else                    t = CNT_W'(32);
    return t;
  endfunction
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              expired,
  output logic [DATA_W-1:0] busRdata,
  output wdStrobe_t         stb,
  output logic              modeEn,
  output logic [3:0]        modeCode,
  output logic [1:0]        cfgAct
);
  logic selCtrl, selCfg, selMode;
  logic wrCtrl, wrCfg, wrMode, keyOk;
  logic [3:0] newCode;
  logic newEn;

  assign selCtrl = busAddr == ADDR_W'(OFF_CTRL);
  assign selCfg  = busAddr == ADDR_W'(OFF_CFG);
  assign selMode = busAddr == ADDR_W'(OFF_MODE);
  assign wrCtrl  = busSel && busWr && selCtrl;
  assign wrCfg   = busSel && busWr && selCfg;
  assign wrMode  = busSel && busWr && selMode;
  assign keyOk   = busWdata == RESTART_WORD;
  assign newCode = busWdata[7:4];
  assign newEn   = busWdata[0];

  always_comb begin
    stb.clearExp = wrCtrl && keyOk;
    stb.reload   = (wrCtrl && keyOk) ||
                   (wrMode && ((newCode != modeCode) || (newEn && !modeEn)));
    stb.loadCode = wrMode ? newCode : modeCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeEn   <= 1'b0;
      modeCode <= 4'd0;
      cfgAct   <= 2'd0;
    end else begin
      if (wrMode) begin
        modeEn   <= newEn;
        modeCode <= newCode;
      end
      if (wrCfg) cfgAct <= busWdata[1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (selCtrl)      busRdata[DATA_W-1] = expired;
    else if (selCfg)  busRdata[1:0] = cfgAct;
    else if (selMode) busRdata[7:0] = {modeCode, 3'b000, modeEn};
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int PULSE_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  wdStrobe_t  stb,
  input  logic       modeEn,
  input  logic [3:0] modeCode,
  input  logic [1:0] cfgAct,
  output logic       expired,
  output logic       sysRstOut
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] count;
  logic [PW-1:0]    pulseCnt;
  logic             expireEv, fireRst;

  assign expireEv = !stb.reload && modeEn && tickEn && (count <= CNT_W'(1));
  assign fireRst  = expireEv && (cfgAct == 2'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= ticksFor(4'd0);
      expired  <= 1'b0;
      pulseCnt <= '0;
    end else begin
      if (stb.reload)            count <= ticksFor(stb.loadCode);
      else if (expireEv)         count <= ticksFor(modeCode);
      else if (modeEn && tickEn) count <= count - CNT_W'(1);

      if (stb.clearExp)  expired <= 1'b0;
      else if (fireRst)  expired <= 1'b1;

      if (fireRst)               pulseCnt <= PW'(PULSE_CYC);
      else if (pulseCnt != '0)   pulseCnt <= pulseCnt - PW'(1);
    end
  end

  assign sysRstOut = pulseCnt != '0;
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              sysRstOut
);
  wdStrobe_t  stb;
  logic       modeEn, expiredQ;
  logic [3:0] modeCode;
  logic [1:0] cfgAct;

  wdog_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .expired(expiredQ),
    .busRdata(busRdata), .stb(stb), .modeEn(modeEn),
    .modeCode(modeCode), .cfgAct(cfgAct)
  );

  wdog_count #(.PULSE_CYC(PULSE_CYC)) u_count (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .stb(stb),
    .modeEn(modeEn), .modeCode(modeCode), .cfgAct(cfgAct),
    .expired(expiredQ), .sysRstOut(sysRstOut)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              sysRstOut,
  input logic              modeEn,
  input logic [1:0]        cfgAct,
  input logic              expiredQ
);
  logic ctrlWr, ctrlRd;
  logic [3:0] runLen;
  assign ctrlWr = busSel && busWr && busAddr == ADDR_W'(8'h10);
  assign ctrlRd = busSel && !busWr && busAddr == ADDR_W'(8'h10);

  always_ff @(posedge clk) begin
    if (!rstN)          runLen <= '0;
    else if (sysRstOut) runLen <= (runLen == 4'hF) ? runLen : runLen + 4'd1;
    else                runLen <= '0;
  end

  a_r2_key_clears: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && busWdata == 32'h0000_14AF |=> !expiredQ);
  a_r2_bad_key_keeps: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && busWdata != 32'h0000_14AF && expiredQ |=> expiredQ);
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !modeEn && !sysRstOut |=> !sysRstOut);
  a_r7_action_gate: assert property (@(posedge clk) disable iff (!rstN)
    cfgAct != 2'd1 && !sysRstOut |=> !sysRstOut);
  a_r7_rise_flags: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstOut) |-> expiredQ);
  a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysRstOut) |-> runLen >= 4'd4);
  a_r10_key_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRd |-> busRdata[30:0] == 31'd0);
endmodule

bind wdog_keyed wdog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .sysRstOut(sysRstOut), .modeEn(modeEn), .cfgAct(cfgAct),
  .expiredQ(expiredQ)
);

// File: tb/sim_wdog_keyed.sv
module sim_wdog_keyed;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h10, A_CFG = 8'h14, A_MODE = 8'h18;
  localparam logic [31:0] KEY = 32'h0000_14AF;

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic sysRstOut;
  int checks = 0, errors = 0, cycles = 0;

  wdog_keyed u0 (.clk(clk), .rstN(rstN), .tickEn(tickEn), .busSel(busSel),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .sysRstOut(sysRstOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(posedge clk);
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
    wr(A_CTRL, KEY);
    wr(A_MODE, 32'h0);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    check("R6 reset sysRstOut", {31'd0, sysRstOut}, 32'd0);
    rd(A_CTRL, v); check("R6 ctrl after reset", v, 32'd0);
    rd(A_CFG, v);  check("R6 cfg after reset", v, 32'd0);
    rd(A_MODE, v); check("R6 mode after reset", v, 32'd0);
  endtask

  task automatic test_regs();
    logic [31:0] v;
    wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, v); check("R1 cfg field", v, 32'd3);
    wr(A_MODE, 32'hFFFF_FF2E); rd(A_MODE, v); check("R1 mode fields", v, 32'h20);
    wr(A_MODE, 32'h0); rd(A_MODE, v); check("R3 mode stop", v, 32'd0);
    rd(8'h1C, v); check("R1 unmapped read", v, 32'd0);
    wr(A_CTRL, KEY); rd(A_CTRL, v); check("R10 key reads zero", v, 32'd0);
  endtask

  task automatic measure(input logic [3:0] code, input int n, input string req);
    logic [31:0] v;
    wr(A_CFG, 32'd1);
    wr(A_MODE, 32'h0);
    wr(A_MODE, {24'd0, code, 4'h1});
    ticks(n - 1);
    check({req, " no expiry before N"}, {31'd0, sysRstOut}, 32'd0);
    ticks(1);
    check({req, " expiry at N"}, {31'd0, sysRstOut}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 pulse held", {31'd0, sysRstOut}, 32'd1);
    end
    @(negedge clk);
    check("R7 pulse ends after 4", {31'd0, sysRstOut}, 32'd0);
    rd(A_CTRL, v); check("R7 sticky flag", v, 32'h8000_0000);
    settle();
  endtask

  task automatic test_key();
    logic [31:0] v;
    wr(A_CFG, 32'd1);
    wr(A_MODE, 32'h21);
    ticks(3);
    wr(A_CTRL, 32'h0000_14AE);
    wr(A_CTRL, 32'h0000_14B1);
    wr(A_CTRL, 32'h0001_14AF);
    ticks(1);
    check("R2 bad key ignored", {31'd0, sysRstOut}, 32'd1);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h0000_14AE);
    rd(A_CTRL, v); check("R2 bad key keeps flag", v, 32'h8000_0000);
    wr(A_CTRL, KEY);
    rd(A_CTRL, v); check("R2 key clears flag", v, 32'd0);
    ticks(3);
    wr(A_CTRL, KEY);
    ticks(3);
    check("R2 key reloads", {31'd0, sysRstOut}, 32'd0);
    ticks(1);
    check("R2 expiry after reload", {31'd0, sysRstOut}, 32'd1);
    settle();
  endtask

  task automatic test_action();
    logic [31:0] v;
    wr(A_CFG, 32'd2);
    wr(A_MODE, 32'h01);
    ticks(3);
    check("R7 action 2 no pulse", {31'd0, sysRstOut}, 32'd0);
    rd(A_CTRL, v); check("R7 action 2 no flag", v, 32'd0);
    settle();
  endtask

  task automatic test_disable();
    wr(A_CFG, 32'd1);
    wr(A_MODE, 32'h01);
    wr(A_MODE, 32'h0);
    ticks(3);
    check("R3 stopped no expiry", {31'd0, sysRstOut}, 32'd0);
    wr(A_MODE, 32'h10);
    ticks(4);
    check("R3 disabled no expiry", {31'd0, sysRstOut}, 32'd0);
    settle();
  endtask

  task automatic test_rewrite();
    logic [31:0] v;
    wr(A_CFG, 32'd1);
    wr(A_MODE, 32'h21);
    ticks(3);
    wr(A_MODE, 32'h21);
    rd(A_MODE, v); check("R8 code kept", v, 32'h21);
    ticks(1);
    check("R8 rewrite no reload", {31'd0, sysRstOut}, 32'd1);
    settle();
    wr(A_MODE, 32'h21);
    ticks(3);
    wr(A_MODE, 32'h31);
    ticks(5);
    check("R9 code change reloads", {31'd0, sysRstOut}, 32'd0);
    ticks(1);
    check("R9 new interval expiry", {31'd0, sysRstOut}, 32'd1);
    settle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_regs();
    measure(4'h0, 1, "R4 code0");
    measure(4'h1, 2, "R4 code1");
    measure(4'h6, 12, "R4 code6");
    measure(4'h7, 16, "R4 code7");
    measure(4'h9, 24, "R4 code9");
    measure(4'hB, 32, "R4 codeB");
    measure(4'hC, 32, "R5 codeC");
    measure(4'hF, 32, "R5 codeF");
    test_key();
    test_action();
    test_disable();
    test_rewrite();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule